// File: doc/BRIEF.md
# Closed-Loop Fan Speed Controller

The block drives a fan from an 8-bit drive level and a PWM waveform made from it. Software configures it through byte-wide register writes and reads. In direct mode the programmed setting byte is the drive level. In speed mode the block runs a closed loop on a tach-count target, where a larger count means a slower fan. On every update tick it nudges the drive by one step toward the target, and it makes no correction while the error stays inside a programmable dead band.

A separate measurement unit supplies the tach count together with a one-cycle valid strobe. The block keeps the most recent reading in a register that software can read. Three fault flags are kept, and software clears each one by writing 1 to it: stall, spin-up failure and drive failure. Software can switch the fan off with a zero setting in direct mode, or with a target whose high byte is all ones in speed mode. While the fan is off the drive is held at zero and no fault is raised.

Top module: `fan_loop_ctrl`

## Requirements
- R1: When configuration-1 (address 0x02) bit 7 is 0 the block is in direct mode, and the drive output follows the setting register (address 0x00) with a latency of one clock after the register holds the value.
- R2: The PWM output is high for exactly `drive` of every 256 consecutive clocks. A drive of 0 keeps it low and a drive of 255 keeps it high for 255 clocks.
- R3: Reads return configuration-1 at 0x02, configuration-2 at 0x03, target low and high bytes at 0x0C and 0x0D, the setting at 0x00, reading low and high at 0x0E and 0x0F, and status at 0x11. Unmapped addresses read 0. The reading registers load only on the clock where tach_valid is 1.
- R4: The update period is PERIOD_BASE << cfg1[2:0] clocks. In speed mode each tick changes the drive by exactly one step at most.
- R5: The dead band is cfg2[2:1] × BAND_STEP counts, where a count is bits 15:3 of the target or reading. When the reading is not more than the band above or below the target, the drive is unchanged. Beyond the band the drive rises when the reading is larger and falls when it is smaller.
- R6: In speed mode the drive saturates at 0 and 255.
- R7: The fan is off in speed mode when the target high byte is 0xFF, and in direct mode when the setting is 0. The drive is then 0 from the next clock, and no status bit sets.
- R8: Status bit 5 (drive failure) sets on a tick in speed mode when the drive has been 255 since the previous tick and the reading is still above target plus band.
- R9: In speed mode with the fan on and a reading high byte of 0xFF, the first tick after switch-on sets status bit 1 (spin-up failure), and later ticks set status bit 0 (stall). Faults are never raised in direct mode.
- R10: Writing status clears each flag whose written bit is 1 and leaves the flags written with 0. A flag set in the same clock wins over the clear.
- R11: After reset every register reads 0, so the block is in direct mode and off, the drive is 0 and the PWM output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| tach_count | input | 16 | Tach measurement, count in bits 15:3 |
| tach_valid | input | 1 | One-cycle strobe marking a new tach_count |
| drive_level | output | 8 | Current drive level |
| pwm_out | output | 1 | PWM waveform of drive_level |

## Verification
The checker assumes that tach_valid is a single-cycle pulse with tach_count stable while it is high. It also assumes that each register write lasts exactly one clock, so every drive change can be attributed to a single tick or configuration edge. The stimulus issues every write and every tach update as a one-cycle strobe at a falling edge. Each drive-step measurement spans a whole multiple of the update period after the last configuration change, so the expected step count does not depend on the free-running timer phase. Status writes that clear flags are issued only while the condition that sets them is absent, so the set-over-clear priority is covered by the assertions and not relied on by the directed checks.

// File: rtl/fan_ctl_pkg.sv
package fan_ctl_pkg;
   localparam int unsigned ADDR_W   = 5;
   localparam int unsigned DRIVE_W  = 8;
   localparam int unsigned TACH_W   = 16;
   localparam int unsigned FRAC_W   = 3;
   localparam int unsigned CNT_W    = TACH_W - FRAC_W;
   localparam int unsigned NFLAG    = 3;

   localparam logic [ADDR_W-1:0] A_SETTING = 5'h00;
   localparam logic [ADDR_W-1:0] A_CFG1    = 5'h02;
   localparam logic [ADDR_W-1:0] A_CFG2    = 5'h03;
   localparam logic [ADDR_W-1:0] A_TGT_LO  = 5'h0C;
   localparam logic [ADDR_W-1:0] A_TGT_HI  = 5'h0D;
   localparam logic [ADDR_W-1:0] A_RD_LO   = 5'h0E;
   localparam logic [ADDR_W-1:0] A_RD_HI   = 5'h0F;
   localparam logic [ADDR_W-1:0] A_STATUS  = 5'h11;

   // flag index -> status bit position (stall, spin-up fail, drive fail)
   localparam int unsigned FLAG_POS [NFLAG] = '{0, 1, 5};

   typedef struct packed {
      logic       speed_mode;
      logic [2:0] period_code;
      logic [1:0] band_code;
   } ctl_t;
endpackage

// File: rtl/fan_regs.sv
module fan_regs
   import fan_ctl_pkg::*;
(
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [ADDR_W-1:0]        addr,
   input  logic [7:0]               wdata,
   output logic [7:0]               rdata,
   input  logic [TACH_W-1:0]        tach_in,
   input  logic                     tach_stb,
   input  logic [NFLAG-1:0]         flag_set,
   output ctl_t                     ctl,
   output logic [DRIVE_W-1:0]       setting,
   output logic [CNT_W-1:0]         tgt_cnt,
   output logic [CNT_W-1:0]         rd_cnt,
   output logic [7:0]               status
);
   logic [7:0]        setting_q, cfg1_q, cfg2_q;
   logic [TACH_W-1:0] target_q, reading_q;
   logic [NFLAG-1:0]  flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         setting_q <= '0;
         cfg1_q    <= '0;
         cfg2_q    <= '0;
         target_q  <= '0;
      end else if (wr_en) begin
         case (addr)
            A_SETTING: setting_q      <= wdata;
            A_CFG1:    cfg1_q         <= wdata;
            A_CFG2:    cfg2_q         <= wdata;
            A_TGT_LO:  target_q[7:0]  <= wdata;
            A_TGT_HI:  target_q[15:8] <= wdata;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        reading_q <= '0;
      else if (tach_stb) reading_q <= tach_in;
   end

   generate
      for (genvar i = 0; i < NFLAG; i++) begin : g_flag
         logic clr;
         assign clr = wr_en && (addr == A_STATUS) && wdata[FLAG_POS[i]];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           flag_q[i] <= 1'b0;
            else if (flag_set[i]) flag_q[i] <= 1'b1;
            else if (clr)         flag_q[i] <= 1'b0;
         end
      end
   endgenerate

   always_comb begin
      status = '0;
      for (int i = 0; i < NFLAG; i++) status[FLAG_POS[i]] = flag_q[i];
   end

   always_comb begin
      case (addr)
         A_SETTING: rdata = setting_q;
         A_CFG1:    rdata = cfg1_q;
         A_CFG2:    rdata = cfg2_q;
         A_TGT_LO:  rdata = target_q[7:0];
         A_TGT_HI:  rdata = target_q[15:8];
         A_RD_LO:   rdata = reading_q[7:0];
         A_RD_HI:   rdata = reading_q[15:8];
         A_STATUS:  rdata = status;
         default:   rdata = '0;
      endcase
   end

   assign ctl.speed_mode  = cfg1_q[7];
   assign ctl.period_code = cfg1_q[2:0];
   assign ctl.band_code   = cfg2_q[2:1];
   assign setting = setting_q;
   assign tgt_cnt = target_q[TACH_W-1:FRAC_W];
   assign rd_cnt  = reading_q[TACH_W-1:FRAC_W];
endmodule

// File: rtl/fan_timer.sv
module fan_timer #(
   parameter int unsigned PERIOD_BASE = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] code,
   output logic       tick
);
   localparam int unsigned MAXP = PERIOD_BASE << 7;
   localparam int unsigned CW   = $clog2(MAXP + 1);

   logic [CW-1:0] cnt_q, limit;

   assign limit = CW'(PERIOD_BASE) << code;
   assign tick  = (cnt_q >= limit - CW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt_q <= '0;
      else if (tick) cnt_q <= '0;
      else           cnt_q <= cnt_q + CW'(1);
   end
endmodule

// File: rtl/fan_servo.sv
module fan_servo
   import fan_ctl_pkg::*;
#(
   parameter int unsigned BAND_STEP = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  ctl_t               ctl,
   input  logic [DRIVE_W-1:0] setting,
   input  logic [CNT_W-1:0]   tgt_cnt,
   input  logic [CNT_W-1:0]   rd_cnt,
   input  logic               tick,
   output logic [DRIVE_W-1:0] drive,
   output logic               fan_off,
   output logic [NFLAG-1:0]   flag_set
);
   localparam int unsigned EW = CNT_W + 2;
   localparam logic [DRIVE_W-1:0] DMAX = '1;

   logic [DRIVE_W-1:0] drive_q;
   logic [EW-1:0]      band, tgt_e, rd_e;
   logic               too_slow, too_fast, stalled, active;
   logic               first_q, maxhold_q;

   assign band     = EW'(ctl.band_code) * EW'(BAND_STEP);
   assign tgt_e    = EW'(tgt_cnt);
   assign rd_e     = EW'(rd_cnt);
   assign too_slow = rd_e > tgt_e + band;
   assign too_fast = rd_e + band < tgt_e;
   assign stalled  = (rd_cnt[CNT_W-1:CNT_W-8] == 8'hFF);
   assign fan_off  = ctl.speed_mode ? (tgt_cnt[CNT_W-1:CNT_W-8] == 8'hFF)
                                    : (setting == '0);
   assign active   = ctl.speed_mode && !fan_off && tick;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                drive_q <= '0;
      else if (fan_off)          drive_q <= '0;
      else if (!ctl.speed_mode)  drive_q <= setting;
      else if (tick) begin
         if (too_slow && drive_q != DMAX)     drive_q <= drive_q + 1'b1;
         else if (too_fast && drive_q != '0)  drive_q <= drive_q - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         first_q <= 1'b1;
      else if (fan_off || !ctl.speed_mode) first_q <= 1'b1;
      else if (tick)                      first_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                          maxhold_q <= 1'b0;
      else if (fan_off || !ctl.speed_mode || drive_q != DMAX) maxhold_q <= 1'b0;
      else if (tick)                                       maxhold_q <= 1'b1;
   end

   assign flag_set[0] = active && stalled && !first_q;
   assign flag_set[1] = active && stalled && first_q;
   assign flag_set[2] = active && maxhold_q && (drive_q == DMAX) && too_slow;
   assign drive = drive_q;
endmodule

// File: rtl/fan_pwm.sv
module fan_pwm #(
   parameter int unsigned PWM_W   = 8,
   parameter bit          REG_OUT = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PWM_W-1:0] duty,
   output logic             pwm
);
   logic [PWM_W-1:0] ramp_q;
   logic             raw;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ramp_q <= '0;
      else        ramp_q <= ramp_q + 1'b1;
   end

   assign raw = (ramp_q < duty);

   generate
      if (REG_OUT) begin : g_reg
         logic pwm_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pwm_q <= 1'b0;
            else        pwm_q <= raw;
         end
         assign pwm = pwm_q;
      end else begin : g_comb
         assign pwm = raw;
      end
   endgenerate
endmodule

// File: rtl/fan_loop_ctrl.sv
module fan_loop_ctrl
   import fan_ctl_pkg::*;
#(
   parameter int unsigned PERIOD_BASE = 4,
   parameter int unsigned BAND_STEP   = 4,
   parameter bit          PWM_REG_OUT = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_we,
   input  logic [ADDR_W-1:0]   reg_addr,
   input  logic [7:0]          reg_wdata,
   output logic [7:0]          reg_rdata,
   input  logic [TACH_W-1:0]   tach_count,
   input  logic                tach_valid,
   output logic [DRIVE_W-1:0]  drive_level,
   output logic                pwm_out
);
   generate
      if (PERIOD_BASE < 1)              $error("PERIOD_BASE must be at least 1");
      if (BAND_STEP * 3 >= (1 << CNT_W)) $error("BAND_STEP too large for count width");
   endgenerate

   ctl_t               ctl;
   logic [DRIVE_W-1:0] setting;
   logic [CNT_W-1:0]   tgt_cnt, rd_cnt;
   logic [7:0]         status;
   logic [NFLAG-1:0]   flag_set;
   logic               tick, fan_off, speed_mode;

   assign speed_mode = ctl.speed_mode;

   fan_regs u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_we), .addr(reg_addr),
      .wdata(reg_wdata), .rdata(reg_rdata), .tach_in(tach_count),
      .tach_stb(tach_valid), .flag_set(flag_set), .ctl(ctl),
      .setting(setting), .tgt_cnt(tgt_cnt), .rd_cnt(rd_cnt), .status(status)
   );

   fan_timer #(.PERIOD_BASE(PERIOD_BASE)) u_timer (
      .clk(clk), .rst_n(rst_n), .code(ctl.period_code), .tick(tick)
   );

   fan_servo #(.BAND_STEP(BAND_STEP)) u_servo (
      .clk(clk), .rst_n(rst_n), .ctl(ctl), .setting(setting),
      .tgt_cnt(tgt_cnt), .rd_cnt(rd_cnt), .tick(tick),
      .drive(drive_level), .fan_off(fan_off), .flag_set(flag_set)
   );

   fan_pwm #(.PWM_W(DRIVE_W), .REG_OUT(PWM_REG_OUT)) u_pwm (
      .clk(clk), .rst_n(rst_n), .duty(drive_level), .pwm(pwm_out)
   );
endmodule

// File: rtl/fan_loop_ctrl_chk.sv
module fan_loop_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       speed_mode,
   input logic       fan_off,
   input logic [7:0] setting,
   input logic [12:0] tgt_cnt,
   input logic [7:0] status,
   input logic [7:0] drive_level,
   input logic       pwm_out
);
   p_direct_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !speed_mode |=> drive_level == $past(setting));

   p_pwm_idle_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (drive_level == 8'd0 && $past(drive_level) == 8'd0) |-> !pwm_out);

   p_single_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (speed_mode && !fan_off) |=> (drive_level == $past(drive_level)
         || drive_level == $past(drive_level) + 8'd1
         || drive_level == $past(drive_level) - 8'd1));

   p_off_target_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (speed_mode && tgt_cnt[12:5] == 8'hFF) |=> drive_level == 8'd0);

   p_off_no_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
      fan_off |=> (status & ~$past(status)) == 8'h00);

   p_drvfail_at_max_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[5]) |-> $past(drive_level) == 8'hFF);

   p_no_fault_direct_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !speed_mode |=> (status & ~$past(status)) == 8'h00);
endmodule

bind fan_loop_ctrl fan_loop_ctrl_chk u_chk (
   .clk(clk), .rst_n(rst_n), .speed_mode(speed_mode), .fan_off(fan_off),
   .setting(setting), .tgt_cnt(tgt_cnt), .status(status),
   .drive_level(drive_level), .pwm_out(pwm_out)
);

// File: tb/tb_fan_loop_ctrl.sv
module tb_fan_loop_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [4:0]  reg_addr = '0;
   logic [7:0]  reg_wdata = '0;
   logic [7:0]  reg_rdata;
   logic [15:0] tach_count = '0;
   logic        tach_valid = 1'b0;
   logic [7:0]  drive_level;
   logic        pwm_out;

   always #2 clk = ~clk;

   fan_loop_ctrl dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tach_count(tach_count),
      .tach_valid(tach_valid), .drive_level(drive_level), .pwm_out(pwm_out)
   );

   typedef struct {
      int    kind;   // 0 drive, 1 rdata, 2 pwm high count, 3 pwm pin
      int    lo;
      int    hi;
      string req;
   } item_t;

   item_t exp_q[$];
   int    checks = 0;
   int    failures = 0;
   int    pwm_hi = 0;
   bit    done = 1'b0;

   // monitor: compares every pending expectation after the falling edge
   initial forever begin
      @(negedge clk);
      #1;
      while (exp_q.size() > 0) begin
         item_t it;
         int    act;
         it = exp_q.pop_front();
         case (it.kind)
            0:       act = int'(drive_level);
            1:       act = int'(reg_rdata);
            2:       act = pwm_hi;
            default: act = int'(pwm_out);
         endcase
         checks++;
         if (act < it.lo || act > it.hi) begin
            failures++;
            $display("FAIL %s: actual %0d expected %0d..%0d", it.req, act, it.lo, it.hi);
         end
      end
   end

   task automatic push(int kind, int lo, int hi, string req);
      item_t it;
      it.kind = kind; it.lo = lo; it.hi = hi; it.req = req;
      exp_q.push_back(it);
   endtask

   task automatic wr(logic [4:0] a, logic [7:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic tach(logic [15:0] v);
      @(negedge clk);
      tach_count = v; tach_valid = 1'b1;
      @(negedge clk);
      tach_valid = 1'b0;
   endtask

   task automatic exp_reg(logic [4:0] a, int v, string req);
      @(negedge clk);
      reg_addr = a;
      push(1, v, v, req);
   endtask

   task automatic exp_drive(int v, string req);
      @(negedge clk);
      push(0, v, v, req);
   endtask

   task automatic exp_delta(int n, int delta, string req);
      int d0;
      d0 = int'(drive_level);
      repeat (n) @(negedge clk);
      push(0, d0 + delta, d0 + delta, req);
   endtask

   task automatic exp_pwm_count(int v, string req);
      int hi;
      hi = 0;
      repeat (256) begin
         @(negedge clk);
         hi += int'(pwm_out);
      end
      pwm_hi = hi;
      push(2, v, v, req);
   endtask

   task automatic cnt(int c, output logic [15:0] v);
      v = 16'(c << 3);
   endtask

   initial begin
      #400000;
      if (!done) begin
         failures++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [15:0] v;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;

      // R11 reset state
      exp_drive(0, "R11 drive after reset");
      push(3, 0, 0, "R11 pwm after reset");
      exp_reg(5'h02, 0, "R11 cfg1 after reset");
      exp_reg(5'h11, 0, "R11 status after reset");
      exp_reg(5'h0C, 0, "R11 target after reset");

      // R1 / R2 direct mode
      wr(5'h00, 8'h80);
      repeat (2) @(negedge clk);
      exp_drive(128, "R1 direct drive 0x80");
      exp_pwm_count(128, "R2 pwm count at 128");
      wr(5'h00, 8'hFF);
      repeat (2) @(negedge clk);
      exp_drive(255, "R1 direct drive 0xFF");
      exp_pwm_count(255, "R2 pwm count at 255");
      wr(5'h00, 8'h00);
      repeat (2) @(negedge clk);
      exp_drive(0, "R7 direct zero setting off");
      exp_pwm_count(0, "R2 pwm count at 0");
      wr(5'h00, 8'h40);
      repeat (2) @(negedge clk);
      exp_pwm_count(64, "R2 pwm count at 64");

      // R3 register map
      wr(5'h03, 8'h5E);
      exp_reg(5'h03, 8'h5E, "R3 cfg2 readback");
      wr(5'h0C, 8'h20);
      wr(5'h0D, 8'h03);
      exp_reg(5'h0C, 8'h20, "R3 target low");
      exp_reg(5'h0D, 8'h03, "R3 target high");
      exp_reg(5'h00, 8'h40, "R3 setting readback");
      exp_reg(5'h05, 0, "R3 unmapped reads zero");
      tach(16'h1234);
      exp_reg(5'h0E, 8'h34, "R3 reading low");
      exp_reg(5'h0F, 8'h12, "R3 reading high");
      @(negedge clk);
      tach_count = 16'hABCD;
      exp_reg(5'h0E, 8'h34, "R3 reading holds without valid");

      // R4 speed mode steps, band code 1 -> 4 counts
      wr(5'h00, 8'h10);
      wr(5'h03, 8'h02);
      cnt(200, v); tach(v);
      wr(5'h80 >> 3 == 0 ? 5'h02 : 5'h02, 8'h80);
      exp_delta(40, 10, "R4 ten steps up in 40 clocks at period 4");
      wr(5'h02, 8'h82);
      exp_delta(64, 4, "R4 four steps in 64 clocks at period 16");
      wr(5'h02, 8'h80);

      // R5 dead band
      cnt(104, v); tach(v);
      exp_delta(40, 0, "R5 reading at target plus band no change");
      cnt(96, v); tach(v);
      exp_delta(40, 0, "R5 reading at target minus band no change");
      cnt(105, v); tach(v);
      exp_delta(40, 10, "R5 reading above band rises");
      cnt(95, v); tach(v);
      exp_delta(40, -10, "R5 reading below band falls");

      // R6 clamp low
      cnt(50, v); tach(v);
      repeat (300) @(negedge clk);
      exp_drive(0, "R6 clamp at 0");
      exp_delta(40, 0, "R6 stays at 0");
      exp_reg(5'h11, 0, "R8 no fault when fast");

      // R6 clamp high, R8 drive failure
      cnt(1000, v); tach(v);
      repeat (1100) @(negedge clk);
      exp_drive(255, "R6 clamp at 255");
      exp_reg(5'h11, 8'h20, "R8 drive fail set");

      // R10 write-1-to-clear
      cnt(100, v); tach(v);
      repeat (8) @(negedge clk);
      wr(5'h11, 8'h01);
      exp_reg(5'h11, 8'h20, "R10 zero bit leaves flag");
      wr(5'h11, 8'h20);
      exp_reg(5'h11, 8'h00, "R10 one bit clears flag");
      repeat (40) @(negedge clk);
      exp_reg(5'h11, 8'h00, "R8 no fail at 255 inside band");

      // R7 off target in speed mode
      wr(5'h0C, 8'hF8);
      wr(5'h0D, 8'hFF);
      tach(16'hFFFF);
      exp_drive(0, "R7 off target drive zero");
      repeat (40) @(negedge clk);
      exp_reg(5'h11, 0, "R7 no flags while off");
      push(3, 0, 0, "R7 pwm low while off");

      // R9 spin-up failure then stall
      wr(5'h0D, 8'h03);
      repeat (3) @(negedge clk);
      exp_reg(5'h11, 8'h02, "R9 spin-up flag after first tick");
      repeat (4) @(negedge clk);
      exp_reg(5'h11, 8'h03, "R9 stall flag after later tick");
      wr(5'h0D, 8'hFF);
      wr(5'h11, 8'h23);
      exp_reg(5'h11, 0, "R10 clear all three");
      wr(5'h0D, 8'h03);
      exp_delta(40, 10, "R9 drive climbs while stalled");

      // R9 no faults in direct mode
      wr(5'h02, 8'h00);
      wr(5'h11, 8'h23);
      repeat (40) @(negedge clk);
      exp_reg(5'h11, 0, "R9 no faults in direct mode");
      exp_drive(16, "R1 direct mode restores setting");

      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule